// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Flags

This block is a one-way FIFO that carries 36-bit words from a write clock domain to a read clock domain. The two clocks run freely. They may be unrelated, or they may be one shared clock. The write and read pointers cross between the domains as Gray code through two-flop synchronizers. Every flag is a registered output of its own domain.

A static mode input selects how the read side behaves. In standard mode a word stays in the storage array until a read fetches it. `rd_avail` then means "the FIFO is not empty". In fall-through mode the head word is loaded into the output register without any read. `rd_avail` then means "valid data is on `rd_data`", and a read consumes that word. In both modes `wr_room` means "the write side may accept a word".

Two thresholds drive an almost-empty flag and an almost-full flag. A two-bit select is sampled while reset is held. It picks a preset offset of 8, 16 or 64 for both flags. Its fourth code makes the first two writes after reset load the offsets instead of storing data.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with unchanged data. This holds in both modes, with unrelated clocks and with one shared clock.
- R2: In standard mode (`fwft_mode`=0), `rd_avail` is high whenever the array holds at least one word. A word reaches `rd_data` only on the read-clock edge that samples `rd_en` high while `rd_avail` is high. Until then `rd_data` keeps its previous value, which is zero after reset.
- R3: In fall-through mode (`fwft_mode`=1), the head word is placed on `rd_data` and `rd_avail` rises without any read. While `rd_avail` is high and `rd_en` is low, both `rd_avail` and `rd_data` hold. An edge with `rd_en` and `rd_avail` both high consumes the word.
- R4: `wr_room` is low while the array holds DEPTH words. A write presented while `wr_room` is low is dropped: no data is stored and the write pointer does not move. In fall-through mode the output register holds one word in addition to these.
- R5: In standard mode, a read presented while `rd_avail` is low is ignored and the read pointer does not move.
- R6: `almost_empty` is high when the number of words in the array is at or below the empty offset. The array count leaves out a word held in the fall-through output register.
- R7: `almost_full` is high when the number of words in the array exceeds DEPTH minus the full offset.
- R8: `thr_sel` is sampled while reset is in force. Code 01 selects 8, code 10 selects 16 and code 11 selects 64, used as both offsets.
- R9: With `thr_sel` = 00, the first two writes after reset are not stored. The first loads the empty offset and the second loads the full offset, each taken from `wr_data[log2(DEPTH):0]`.
- R10: `arst_n` low resets the block asynchronously. After reset, `rd_avail`=0, `wr_room`=1, `almost_empty`=1 and `almost_full`=0.
- R11: With a shared clock, a write into an empty FIFO raises `rd_avail` after the third following edge in standard mode, and after the fourth in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchronizer |
| fwft_mode | input | 1 | Static read mode: 0 standard, 1 fall-through |
| thr_sel | input | 2 | Threshold select sampled during reset (00 load, 01 = 8, 10 = 16, 11 = 64) |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | DATA_W | Write data, or offset value during the load phase |
| wr_room | output | 1 | Not full / input ready |
| almost_full | output | 1 | Array count above DEPTH minus the full offset |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | DATA_W | Read data register |
| rd_avail | output | 1 | Not empty (standard) / output ready (fall-through) |
| almost_empty | output | 1 | Array count at or below the empty offset |

## Verification
Each result falls due a fixed number of edges after its stimulus. A write raises `rd_avail` after the third read edge in standard mode and after the fourth in fall-through mode. A standard read updates `rd_data` on the edge that samples `rd_en`. A read reaches `wr_room` and `almost_full` after the third write edge. The shared-clock test counts these edges one by one and samples at the falling edge between them. Every test with unrelated clocks first waits twelve edges of each clock, so that all synchronizer and flag registers have settled before it compares a flag with the count it predicts.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    THR_LOAD = 2'b00,
    THR_8    = 2'b01,
    THR_16   = 2'b10,
    THR_64   = 2'b11
  } thr_sel_e;

  // Preset offset selected by the strap code; the load code starts at zero.
  function automatic int unsigned thr_preset(thr_sel_e sel);
    case (sel)
      THR_8:   return 8;
      THR_16:  return 16;
      THR_64:  return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
// Two-flop synchronizer with asynchronous clear; also used as a reset releaser.
module dcf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
// Two-clock storage array with a registered read port.
module dcf_ram #(
  parameter int DATA_W = 36,
  parameter int AW     = 11
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/dcf_wr_side.sv
// Write domain: pointer, full / almost-full flags, offset load and presets.
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  thr_sel_e      thr_sel,
  input  logic          wr_en,
  input  logic [AW:0]   cfg_data,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          wr_room,
  output logic          almost_full,
  output logic [AW:0]   ae_off
);

  localparam int PW = AW + 1;
  localparam logic [AW+1:0] DEPTH_X = (AW+2)'(1 << AW);

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, cnt_d;
  logic        full_q, full_d, af_q, af_d;
  logic [1:0]  load_q, load_d;
  logic [AW:0] ae_off_q, ae_off_d, af_off_q, af_off_d;
  logic        load_hit, push;

  // Next-state logic
  always_comb begin
    load_hit = wr_en && (load_q != 2'd0);
    push     = wr_en && !full_q && (load_q == 2'd0);

    load_d   = load_q;
    ae_off_d = ae_off_q;
    af_off_d = af_off_q;
    if (load_hit) begin
      load_d = load_q - 2'd1;
      if (load_q == 2'd2) begin
        ae_off_d = cfg_data;
      end else begin
        af_off_d = cfg_data;
      end
    end

    rbin_s = rgray_s;
    for (int i = AW - 1; i >= 0; i--) begin
      rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    wbin_d  = wbin_q + {{AW{1'b0}}, push};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    cnt_d   = wbin_d - rbin_s;
    full_d  = (cnt_d == DEPTH_X[AW:0]);
    af_d    = ({1'b0, cnt_d} > (DEPTH_X - {1'b0, af_off_q}));
  end

  // Threshold state: captured from the strap while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= (thr_sel == THR_LOAD) ? 2'd2 : 2'd0;
      ae_off_q <= PW'(thr_preset(thr_sel));
      af_off_q <= PW'(thr_preset(thr_sel));
    end else begin
      load_q   <= load_d;
      ae_off_q <= ae_off_d;
      af_off_q <= af_off_d;
    end
  end

  // Pointer and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      af_q    <= af_d;
    end
  end

  assign wgray       = wgray_q;
  assign waddr       = wbin_q[AW-1:0];
  assign we          = push;
  assign wr_room     = !full_q;
  assign almost_full = af_q;
  assign ae_off      = ae_off_q;

endmodule

// File: rtl/dcf_rd_side.sv
// Read domain: pointer, empty / almost-empty flags, fall-through output control.
module dcf_rd_side #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   ae_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          rd_avail,
  output logic          almost_empty
);

  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, cnt_d;
  logic        empty_q, empty_d, ov_q, ov_d, ae_q, ae_d, re_c;

  // Next-state logic
  always_comb begin
    wbin_s = wgray_s;
    for (int i = AW - 1; i >= 0; i--) begin
      wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    if (fwft) begin
      re_c = !empty_q && (!ov_q || rd_en);
      ov_d = re_c || (ov_q && !rd_en);
    end else begin
      re_c = rd_en && !empty_q;
      ov_d = 1'b0;
    end

    rbin_d  = rbin_q + {{AW{1'b0}}, re_c};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    cnt_d   = wbin_s - rbin_d;
    empty_d = (cnt_d == '0);
    ae_d    = (cnt_d <= ae_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      ae_q    <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
      ov_q    <= ov_d;
      ae_q    <= ae_d;
    end
  end

  assign rgray        = rgray_q;
  assign raddr        = rbin_q[AW-1:0];
  assign re           = re_c;
  assign rd_avail     = fwft ? ov_q : !empty_q;
  assign almost_empty = ae_q;

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              fwft_mode,
  input  logic [1:0]        thr_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_room,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail,
  output logic              almost_empty
);

  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic             wr_rst_n_s, rd_rst_n_s;
  logic [PTR_W-1:0] wptr_gray, rptr_gray, wgray_rs, rgray_ws;
  logic [PTR_W-1:0] ae_off;
  logic [AW-1:0]    waddr, raddr;
  logic             we, re;

  dcf_sync2 #(.W(1)) u_wrst (
    .clk(wr_clk), .rst_n(arst_n), .d(1'b1), .q(wr_rst_n_s)
  );

  dcf_sync2 #(.W(1)) u_rrst (
    .clk(rd_clk), .rst_n(arst_n), .d(1'b1), .q(rd_rst_n_s)
  );

  dcf_sync2 #(.W(PTR_W)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n_s), .d(rptr_gray), .q(rgray_ws)
  );

  dcf_sync2 #(.W(PTR_W)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n_s), .d(wptr_gray), .q(wgray_rs)
  );

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk         (wr_clk),
    .rst_n       (wr_rst_n_s),
    .thr_sel     (thr_sel_e'(thr_sel)),
    .wr_en       (wr_en),
    .cfg_data    (wr_data[AW:0]),
    .rgray_s     (rgray_ws),
    .wgray       (wptr_gray),
    .waddr       (waddr),
    .we          (we),
    .wr_room     (wr_room),
    .almost_full (almost_full),
    .ae_off      (ae_off)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .clk          (rd_clk),
    .rst_n        (rd_rst_n_s),
    .fwft         (fwft_mode),
    .rd_en        (rd_en),
    .wgray_s      (wgray_rs),
    .ae_off       (ae_off),
    .rgray        (rptr_gray),
    .raddr        (raddr),
    .re           (re),
    .rd_avail     (rd_avail),
    .almost_empty (almost_empty)
  );

  dcf_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .wclk   (wr_clk),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rclk   (rd_clk),
    .rrst_n (rd_rst_n_s),
    .re     (re),
    .raddr  (raddr),
    .rdata  (rd_data)
  );

endmodule

// File: rtl/dual_clock_flag_fifo_chk.sv
module dual_clock_flag_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int PTR_W  = 12
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              fwft_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_room,
  input logic              rd_avail,
  input logic              almost_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  wptr_gray,
  input logic [PTR_W-1:0]  rptr_gray
);

  // R4: a write refused for lack of room leaves the write pointer alone
  assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && !wr_room) |=> $stable(wptr_gray));

  // R5: a standard-mode read with nothing stored leaves the read pointer alone
  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!fwft_mode && rd_en && !rd_avail) |=> $stable(rptr_gray));

  // R1: pointers that cross domains change by at most one bit per edge
  assert_wgray_step_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  assert_rgray_step_R1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

  // R3: fall-through output holds until consumed
  assert_fwft_hold_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (fwft_mode && rd_avail && !rd_en) |=> (rd_avail && $stable(rd_data)));

  // R6: an empty array always reports almost-empty
  assert_empty_is_low_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!fwft_mode && !rd_avail) |-> almost_empty);

endmodule

bind dual_clock_flag_fifo dual_clock_flag_fifo_chk #(
  .DATA_W (DATA_W),
  .PTR_W  (PTR_W)
) u_chk (
  .wr_clk       (wr_clk),
  .rd_clk       (rd_clk),
  .wr_rst_n     (wr_rst_n_s),
  .rd_rst_n     (rd_rst_n_s),
  .fwft_mode    (fwft_mode),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .wr_room      (wr_room),
  .rd_avail     (rd_avail),
  .almost_empty (almost_empty),
  .rd_data      (rd_data),
  .wptr_gray    (wptr_gray),
  .rptr_gray    (rptr_gray)
);

// File: tb/dual_clock_flag_fifo_tb.sv
module dual_clock_flag_fifo_tb;

  localparam int DW    = 36;
  localparam int DEPTH = 128;

  logic          clk_a = 1'b0, clk_b = 1'b0, shared = 1'b0;
  logic          wr_clk, rd_clk;
  logic          arst_n = 1'b0, fwft_mode = 1'b0;
  logic [1:0]    thr_sel = 2'd1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_room, almost_full, rd_avail, almost_empty;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q[$];

  always #10 clk_a = ~clk_a;  // 50 MHz
  always #7  clk_b = ~clk_b;
  assign wr_clk = clk_a;
  assign rd_clk = shared ? clk_a : clk_b;

  dual_clock_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .fwft_mode(fwft_mode),
    .thr_sel(thr_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room),
    .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
    .rd_avail(rd_avail), .almost_empty(almost_empty)
  );

  // fwft, shared clock, strap, words written, expected ae / af / room
  typedef struct packed {
    logic       fwft;
    logic       shr;
    logic [1:0] sel;
    logic [8:0] n;
    logic       ae;
    logic       af;
    logic       room;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd1, 9'd8,   1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd1, 9'd9,   1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'd2, 9'd17,  1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd2, 9'd18,  1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 2'd3, 9'd64,  1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd3, 9'd65,  1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 2'd1, 9'd121, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd1, 9'd122, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 2'd2, 9'd128, 1'b0, 1'b1, 1'b0}
  };

  function automatic logic [DW-1:0] mk(input int t, input int i);
    return {4'hA, t[7:0], i[23:0]};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fw, input logic shr, input logic [1:0] sel);
    @(negedge clk_a);
    arst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    fwft_mode = fw; shared = shr; thr_sel = sel;
    repeat (4) @(negedge clk_a);
    arst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    q.delete();
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic push_burst(input int n, input int tag);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = mk(tag, i);
      if (wr_room) q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg_write(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_all(input string req);
    int guard;
    guard = 0;
    while (q.size() > 0 && guard < 4000) begin
      @(negedge rd_clk);
      guard++;
      if (rd_avail) begin
        if (fwft_mode) begin
          chk(req, rd_data, q[0]);
          void'(q.pop_front());
          rd_en = 1'b1;
          @(negedge rd_clk);
          rd_en = 1'b0;
        end else begin
          rd_en = 1'b1;
          @(negedge rd_clk);
          rd_en = 1'b0;
          chk(req, rd_data, q[0]);
          void'(q.pop_front());
        end
      end
    end
    chk(req, DW'(q.size()), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state, R10
    do_reset(1'b0, 1'b0, 2'd1);
    chk("R10 rd_avail", rd_avail, 0);
    chk("R10 wr_room", wr_room, 1);
    chk("R10 almost_empty", almost_empty, 1);
    chk("R10 almost_full", almost_full, 0);

    // Table walk: R1 R4 R6 R7 R8 per entry
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      do_reset(v.fwft, v.shr, v.sel);
      push_burst(int'(v.n), k);
      settle();
      chk("R6 R8 almost_empty", almost_empty, v.ae);
      chk("R7 R8 almost_full", almost_full, v.af);
      chk("R4 wr_room", wr_room, v.room);
      pop_all("R1");
      settle();
      chk("R5 rd_avail after drain", rd_avail, 0);
      chk("R6 almost_empty after drain", almost_empty, 1);
    end

    // R11 and R2: standard mode, shared clock, exact edge count
    do_reset(1'b0, 1'b1, 2'd1);
    @(negedge clk_a); wr_en = 1'b1; wr_data = mk(50, 1);
    @(negedge clk_a); wr_en = 1'b0;
    chk("R11 std edge0", rd_avail, 0);
    @(negedge clk_a); chk("R11 std edge1", rd_avail, 0);
    @(negedge clk_a); chk("R11 std edge2", rd_avail, 0);
    @(negedge clk_a); chk("R11 std edge3", rd_avail, 1);
    repeat (3) @(negedge clk_a);
    chk("R2 no data before read", rd_data, '0);
    rd_en = 1'b1;
    @(negedge clk_a); rd_en = 1'b0;
    chk("R2 data after read", rd_data, mk(50, 1));
    chk("R2 empty after read", rd_avail, 0);

    // R11 and R3: fall-through mode, shared clock
    do_reset(1'b1, 1'b1, 2'd1);
    @(negedge clk_a); wr_en = 1'b1; wr_data = mk(51, 2);
    @(negedge clk_a); wr_en = 1'b0;
    repeat (3) @(negedge clk_a);
    chk("R11 fwft edge3", rd_avail, 0);
    @(negedge clk_a);
    chk("R11 fwft edge4", rd_avail, 1);
    chk("R3 head shown without read", rd_data, mk(51, 2));
    repeat (6) @(negedge clk_a);
    chk("R3 hold flag", rd_avail, 1);
    chk("R3 hold data", rd_data, mk(51, 2));
    rd_en = 1'b1;
    @(negedge clk_a); rd_en = 1'b0;
    chk("R3 consumed", rd_avail, 0);

    // R4: writes while full are dropped
    do_reset(1'b0, 1'b1, 2'd2);
    push_burst(DEPTH, 60);
    settle();
    chk("R4 full", wr_room, 0);
    push_burst(3, 61);
    settle();
    chk("R4 still full", wr_room, 0);
    pop_all("R4 R1");
    settle();
    chk("R4 no extra word", rd_avail, 0);

    // R5: reads while empty are ignored
    do_reset(1'b0, 1'b0, 2'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk); rd_en = 1'b1;
    end
    @(negedge rd_clk); rd_en = 1'b0;
    settle();
    chk("R5 still empty", rd_avail, 0);
    push_burst(1, 70);
    settle();
    chk("R5 word visible", rd_avail, 1);
    pop_all("R5");

    // R9: load mode, first two writes set offsets 5 and 100
    do_reset(1'b0, 1'b0, 2'd0);
    cfg_write(36'd5);
    cfg_write(36'd100);
    settle();
    chk("R9 nothing stored", rd_avail, 0);
    push_burst(5, 80);
    settle();
    chk("R9 ae at offset", almost_empty, 1);
    push_burst(1, 81);
    settle();
    chk("R9 ae above offset", almost_empty, 0);
    push_burst(22, 82);
    settle();
    chk("R9 af at limit", almost_full, 0);
    push_burst(1, 83);
    settle();
    chk("R9 af above limit", almost_full, 1);
    pop_all("R9 R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule